// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block merges a small group of nonmaskable trap requests and a large group of maskable peripheral interrupt requests into one request toward the processor. Each request pulse is latched into a pending flag. Every cycle the block searches the pending flags for a winner. It then presents the winner's vector index and the program-memory address of that index's vector slot. The processor reads that slot to find the service routine.

Each maskable source has an enable bit and a 3-bit user priority. The winner is chosen in two stages. The highest user priority wins first, and the lowest vector index breaks any tie. Traps take the lowest indices and rank above every maskable level. A single table-select input moves every lookup to an alternate vector table. The alternate table has the same layout as the primary table and sits above it in memory. Once the request is raised, the index and address stay fixed until the processor acknowledges them. The acknowledge retires the winner's pending flag.

Top module: `prio_vec_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `cpu_req` is 0, `vec_idx` is 0 and `vec_addr` is 0; all pending flags are clear.
- R2: A pulse on `trap_set[t]` latches a pending flag for vector index t. A pulse on `irq_set[j]` latches one for vector index N_TRAP+j. If the source wins, `cpu_req` goes high at the second rising edge after the pulse is sampled, whichever source it is.
- R3: A pending maskable source competes only when its enable bit is 1, its priority is nonzero and its priority is strictly above `cpu_prio`. A source with priority 0 never raises a request.
- R4: Among competing maskable sources, the one with the higher user priority is presented.
- R5: Among competing sources at the same priority, the lower vector index is presented.
- R6: A pending trap (index 0 to N_TRAP-1) is presented ahead of every maskable source. Enables and `cpu_prio` do not affect traps, and among traps the lower index wins.
- R7: With `alt_sel`=0 at capture, `vec_addr` = 0x000004 + 2·`vec_idx`.
- R8: With `alt_sel`=1 at capture, `vec_addr` = 0x000104 + 2·`vec_idx`.
- R9: While `cpu_req` is 1 and `cpu_ack` is 0, `cpu_req`, `vec_idx` and `vec_addr` hold their values, even when new sources arrive or `alt_sel` or `cpu_prio` change.
- R10: `cpu_ack` sampled with `cpu_req` high clears the presented source's pending flag and drops `cpu_req` for the next cycle. Arbitration then runs again, so another pending winner is presented one cycle later.
- R11: `cpu_ack` sampled while `cpu_req` is low has no effect on pending flags or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_set | input | N_TRAP | One-cycle trap request pulses, bit t is vector index t |
| irq_set | input | N_IRQ | One-cycle interrupt request pulses, bit j is vector index N_TRAP+j |
| irq_en | input | N_IRQ | Per-source enable |
| irq_prio | input | 3·N_IRQ | Per-source user priority, source j at bits [3j+2:3j] |
| cpu_prio | input | 3 | Current processor priority level |
| alt_sel | input | 1 | 1 selects the alternate vector table |
| cpu_ack | input | 1 | Processor accepts the presented vector |
| cpu_req | output | 1 | Interrupt request to the processor |
| vec_idx | output | IDX_W | Vector index of the presented source |
| vec_addr | output | 24 | Program address of the presented vector slot |

## Verification
A request pulse becomes a pending flag at the first edge. The registered request, index and address follow at the second edge. An acknowledge drops the request at the next edge, and the next winner appears one edge after that. The bench drives inputs and samples outputs at falling edges. A behavioural model steps once per clock. It applies the same two-edge pipeline and the same acknowledge timing, and it compares all three outputs at every falling edge. Directed phases cover trap priority, ties, masking thresholds, holding under new arrivals and stray acknowledges. A long random phase covers both table selections.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int PRIO_W = 3;
    localparam int ADDR_W = 24;
    localparam int LVL_W  = PRIO_W + 1;

    typedef logic [PRIO_W-1:0] uprio_t;
    typedef logic [ADDR_W-1:0] vaddr_t;
    typedef logic [LVL_W-1:0]  level_t;

    // Level given to a trap: one above the highest user priority.
    localparam level_t TRAP_LEVEL = level_t'(1 << PRIO_W);
endpackage

// File: rtl/vic_pending.sv
module vic_pending #(
    parameter int N     = 126,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     set_pulse,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [N-1:0]     pend_q
);
    logic [N-1:0] pend_d;

    always_comb begin
        pend_d = pend_q;
        for (int i = 0; i < N; i++) begin
            if (clr_en && (clr_idx == IDX_W'(i))) begin
                pend_d[i] = 1'b0;
            end
        end
        pend_d = pend_d | set_pulse;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int N_TRAP = 8,
    parameter int N_IRQ  = 118,
    parameter int IDX_W  = 7
) (
    input  logic [N_TRAP+N_IRQ-1:0] pend,
    input  logic [N_IRQ-1:0]        irq_en,
    input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
    input  uprio_t                  cpu_prio,
    output logic                    win_valid,
    output logic [IDX_W-1:0]        win_idx
);
    localparam int TOTAL = N_TRAP + N_IRQ;

    level_t lvl [TOTAL];

    generate
        for (genvar t = 0; t < N_TRAP; t++) begin : g_trap
            assign lvl[t] = pend[t] ? TRAP_LEVEL : '0;
        end
        for (genvar j = 0; j < N_IRQ; j++) begin : g_irq
            uprio_t p;
            logic   ok;
            assign p  = irq_prio[j*PRIO_W +: PRIO_W];
            assign ok = pend[N_TRAP+j] && irq_en[j] && (p != '0) && (p > cpu_prio);
            assign lvl[N_TRAP+j] = ok ? {1'b0, p} : '0;
        end
    endgenerate

    // Scan from the top index down; ">=" lets a lower index take over a tie.
    always_comb begin
        level_t best;
        best      = '0;
        win_valid = 1'b0;
        win_idx   = '0;
        for (int i = TOTAL - 1; i >= 0; i--) begin
            if ((lvl[i] != '0) && (lvl[i] >= best)) begin
                best      = lvl[i];
                win_idx   = IDX_W'(i);
                win_valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vic_addr_gen.sv
module vic_addr_gen
    import vic_pkg::*;
#(
    parameter int     IDX_W    = 7,
    parameter vaddr_t PRI_BASE = 24'h000004,
    parameter vaddr_t ALT_BASE = 24'h000104
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             alt,
    output vaddr_t           addr
);
    localparam int PAD_W = ADDR_W - IDX_W - 1;

    vaddr_t base;
    vaddr_t offset;

    assign base   = alt ? ALT_BASE : PRI_BASE;
    assign offset = {{PAD_W{1'b0}}, idx, 1'b0};
    assign addr   = base + offset;
endmodule

// File: rtl/prio_vec_ctrl.sv
module prio_vec_ctrl
    import vic_pkg::*;
#(
    parameter int     N_TRAP   = 8,
    parameter int     N_IRQ    = 118,
    parameter int     IDX_W    = $clog2(N_TRAP + N_IRQ),
    parameter vaddr_t PRI_BASE = 24'h000004,
    parameter vaddr_t ALT_BASE = 24'h000104
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_TRAP-1:0]       trap_set,
    input  logic [N_IRQ-1:0]        irq_set,
    input  logic [N_IRQ-1:0]        irq_en,
    input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0]       cpu_prio,
    input  logic                    alt_sel,
    input  logic                    cpu_ack,
    output logic                    cpu_req,
    output logic [IDX_W-1:0]        vec_idx,
    output logic [ADDR_W-1:0]       vec_addr
);
    localparam int TOTAL = N_TRAP + N_IRQ;

    typedef struct packed {
        logic             req;
        logic [IDX_W-1:0] idx;
        vaddr_t           addr;
    } pres_t;

    pres_t             st_d, st_q;
    logic [TOTAL-1:0]  pend_q;
    logic              win_valid;
    logic [IDX_W-1:0]  win_idx;
    vaddr_t            win_addr;
    logic              retire;

    assign retire = st_q.req && cpu_ack;

    vic_pending #(.N(TOTAL), .IDX_W(IDX_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse ({irq_set, trap_set}),
        .clr_en    (retire),
        .clr_idx   (st_q.idx),
        .pend_q    (pend_q)
    );

    vic_arbiter #(.N_TRAP(N_TRAP), .N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_arb (
        .pend      (pend_q),
        .irq_en    (irq_en),
        .irq_prio  (irq_prio),
        .cpu_prio  (cpu_prio),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    vic_addr_gen #(.IDX_W(IDX_W), .PRI_BASE(PRI_BASE), .ALT_BASE(ALT_BASE)) u_addr (
        .idx  (win_idx),
        .alt  (alt_sel),
        .addr (win_addr)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.req) begin
            if (cpu_ack) begin
                st_d.req = 1'b0;
            end
        end else if (win_valid) begin
            st_d.req  = 1'b1;
            st_d.idx  = win_idx;
            st_d.addr = win_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_req  = st_q.req;
    assign vec_idx  = st_q.idx;
    assign vec_addr = st_q.addr;
endmodule

// File: rtl/prio_vec_ctrl_chk.sv
module prio_vec_ctrl_chk
    import vic_pkg::*;
#(
    parameter int     N_TRAP   = 8,
    parameter int     N_IRQ    = 118,
    parameter int     IDX_W    = 7,
    parameter vaddr_t PRI_BASE = 24'h000004,
    parameter vaddr_t ALT_BASE = 24'h000104
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ack,
    input logic              cpu_req,
    input logic [IDX_W-1:0]  vec_idx,
    input logic [ADDR_W-1:0] vec_addr
);
    vaddr_t slot_base;
    assign slot_base = vec_addr - (vaddr_t'(vec_idx) << 1);

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_ack) |=> (cpu_req && $stable(vec_idx) && $stable(vec_addr))); // R9

    AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ack) |=> !cpu_req); // R10

    AST_ADDR_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> ((slot_base == PRI_BASE) || (slot_base == ALT_BASE))); // R7

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> (int'(vec_idx) < N_TRAP + N_IRQ)); // R2
endmodule

bind prio_vec_ctrl prio_vec_ctrl_chk #(
    .N_TRAP(N_TRAP), .N_IRQ(N_IRQ), .IDX_W(IDX_W),
    .PRI_BASE(PRI_BASE), .ALT_BASE(ALT_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_ack  (cpu_ack),
    .cpu_req  (cpu_req),
    .vec_idx  (vec_idx),
    .vec_addr (vec_addr)
);

// File: tb/sim_prio_vec_ctrl.sv
module sim_prio_vec_ctrl;
    localparam int NT  = 8;
    localparam int NI  = 118;
    localparam int TOT = NT + NI;
    localparam int IW  = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NT-1:0]   trap_set = '0;
    logic [NI-1:0]   irq_set = '0;
    logic [NI-1:0]   irq_en = '0;
    logic [NI*3-1:0] irq_prio = '0;
    logic [2:0]      cpu_prio = '0;
    logic            alt_sel = 1'b0;
    logic            cpu_ack = 1'b0;
    logic            cpu_req;
    logic [IW-1:0]   vec_idx;
    logic [23:0]     vec_addr;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    logic [TOT-1:0] m_pend = '0;
    logic           m_req  = 1'b0;
    int             m_idx  = 0;
    int             m_addr = 0;

    always #4 clk = ~clk;

    prio_vec_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .trap_set(trap_set), .irq_set(irq_set),
        .irq_en(irq_en), .irq_prio(irq_prio), .cpu_prio(cpu_prio),
        .alt_sel(alt_sel), .cpu_ack(cpu_ack), .cpu_req(cpu_req),
        .vec_idx(vec_idx), .vec_addr(vec_addr)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        check(cpu_req === m_req, "cpu_req", int'(cpu_req), int'(m_req));
        if (m_req || !rst_n) begin
            check(int'(vec_idx) == m_idx, "vec_idx", int'(vec_idx), m_idx);
            check(int'(vec_addr) == m_addr, "vec_addr", int'(vec_addr), m_addr);
        end
    endtask

    task automatic tick();
        logic [TOT-1:0] n_pend;
        logic n_req;
        int n_idx, n_addr, best, bl, lv, p;
        n_pend = m_pend; n_req = m_req; n_idx = m_idx; n_addr = m_addr;
        if (m_req) begin
            if (cpu_ack) begin
                n_req = 1'b0;
                n_pend[m_idx] = 1'b0;
            end
        end else begin
            best = -1; bl = 0;
            for (int i = 0; i < TOT; i++) begin
                lv = 0;
                if (i < NT) begin
                    if (m_pend[i]) lv = 8;
                end else begin
                    p = int'(irq_prio[(i-NT)*3 +: 3]);
                    if (m_pend[i] && irq_en[i-NT] && p != 0 && p > int'(cpu_prio)) lv = p;
                end
                if (lv > bl) begin bl = lv; best = i; end
            end
            if (best >= 0) begin
                n_req = 1'b1; n_idx = best;
                n_addr = (alt_sel ? 'h104 : 'h4) + 2 * best;
            end
        end
        n_pend = n_pend | {irq_set, trap_set};
        if (!rst_n) begin
            n_pend = '0; n_req = 1'b0; n_idx = 0; n_addr = 0;
        end
        @(posedge clk);
        @(negedge clk);
        m_pend = n_pend; m_req = n_req; m_idx = n_idx; m_addr = n_addr;
        compare();
        trap_set = '0; irq_set = '0; cpu_ack = 1'b0;
    endtask

    task automatic run(input int n, input bit auto_ack);
        for (int k = 0; k < n; k++) begin
            cpu_ack = auto_ack && m_req;
            tick();
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        irq_en = '0; irq_prio = '0; cpu_prio = '0; alt_sel = 1'b0;
        run(3, 1'b0);
        rst_n = 1'b1;
        run(1, 1'b0);
    endtask

    task automatic set_src(input int j, input int pr, input bit en);
        irq_prio[j*3 +: 3] = 3'(pr);
        irq_en[j] = en;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        checks++;
        $display("FAIL %s watchdog expired actual=0 expected=1", tag);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        tag = "R1";
        do_reset();
        check(cpu_req == 1'b0 && vec_idx == '0 && vec_addr == '0, "idle after reset", int'(vec_addr), 0);

        // R2: two-edge latency, trap and interrupt alike
        tag = "R2";
        set_src(5, 3, 1'b1);
        irq_set[5] = 1'b1;
        run(1, 1'b0);
        check(cpu_req == 1'b0, "req one edge after pulse", int'(cpu_req), 0);
        run(1, 1'b0);
        check(cpu_req == 1'b1 && int'(vec_idx) == NT + 5, "req two edges after pulse", int'(vec_idx), NT + 5);
        run(3, 1'b1);
        trap_set[2] = 1'b1;
        run(2, 1'b0);
        check(cpu_req == 1'b1 && vec_idx == 7'd2, "trap latency", int'(vec_idx), 2);
        run(3, 1'b1);

        // R3: masking by enable, zero priority, threshold
        tag = "R3";
        do_reset();
        set_src(1, 5, 1'b0); set_src(2, 0, 1'b1); set_src(3, 4, 1'b1);
        cpu_prio = 3'd4;
        irq_set[1] = 1'b1; irq_set[2] = 1'b1; irq_set[3] = 1'b1;
        run(6, 1'b0);
        check(cpu_req == 1'b0, "no eligible source", int'(cpu_req), 0);
        cpu_prio = 3'd3;
        run(3, 1'b0);
        check(cpu_req == 1'b1 && int'(vec_idx) == NT + 3, "threshold lowered", int'(vec_idx), NT + 3);
        run(3, 1'b1);
        irq_en[1] = 1'b1;
        run(3, 1'b0);
        check(int'(vec_idx) == NT + 1, "enable raised", int'(vec_idx), NT + 1);
        run(6, 1'b1);

        // R4: higher priority wins
        tag = "R4";
        do_reset();
        set_src(10, 2, 1'b1); set_src(50, 6, 1'b1);
        irq_set[10] = 1'b1; irq_set[50] = 1'b1;
        run(2, 1'b0);
        check(int'(vec_idx) == NT + 50, "higher priority first", int'(vec_idx), NT + 50);
        run(6, 1'b1);

        // R5: tie broken by lower index
        tag = "R5";
        do_reset();
        set_src(40, 4, 1'b1); set_src(3, 4, 1'b1);
        irq_set[40] = 1'b1; irq_set[3] = 1'b1;
        run(2, 1'b0);
        check(int'(vec_idx) == NT + 3, "lower index at tie", int'(vec_idx), NT + 3);
        run(6, 1'b1);

        // R6: traps beat everything, ignore cpu_prio
        tag = "R6";
        do_reset();
        set_src(0, 7, 1'b1);
        cpu_prio = 3'd7;
        irq_set[0] = 1'b1; trap_set[6] = 1'b1; trap_set[4] = 1'b1;
        run(2, 1'b0);
        check(vec_idx == 7'd4, "lowest trap first", int'(vec_idx), 4);
        cpu_prio = 3'd0;
        run(8, 1'b1);

        // R7 / R8: table selection
        tag = "R7";
        do_reset();
        irq_set[NI-1] = 1'b1; set_src(NI - 1, 1, 1'b1);
        run(2, 1'b0);
        check(int'(vec_addr) == 'h4 + 2 * (TOT - 1), "primary table top entry", int'(vec_addr), 'h4 + 2 * (TOT - 1));
        run(3, 1'b1);
        tag = "R8";
        alt_sel = 1'b1;
        trap_set[0] = 1'b1;
        run(2, 1'b0);
        check(int'(vec_addr) == 'h104, "alternate table entry 0", int'(vec_addr), 'h104);
        run(3, 1'b1);

        // R9: hold while unacknowledged
        tag = "R9";
        do_reset();
        set_src(20, 2, 1'b1); set_src(21, 7, 1'b1);
        irq_set[20] = 1'b1;
        run(2, 1'b0);
        irq_set[21] = 1'b1; trap_set[1] = 1'b1; alt_sel = 1'b1; cpu_prio = 3'd6;
        run(5, 1'b0);
        check(int'(vec_idx) == NT + 20 && int'(vec_addr) == 'h4 + 2 * (NT + 20), "held vector", int'(vec_addr), 'h4 + 2 * (NT + 20));

        // R10: acknowledge retires, re-arbitrates
        tag = "R10";
        cpu_ack = 1'b1;
        tick();
        check(cpu_req == 1'b0, "req drops after ack", int'(cpu_req), 0);
        tick();
        check(cpu_req == 1'b1 && vec_idx == 7'd1, "next winner after gap", int'(vec_idx), 1);
        run(6, 1'b1);

        // R11: stray acknowledge ignored
        tag = "R11";
        do_reset();
        for (int k = 0; k < 4; k++) begin
            cpu_ack = 1'b1;
            tick();
        end
        set_src(7, 3, 1'b1);
        irq_set[7] = 1'b1;
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b1;
        tick();
        check(cpu_req == 1'b1 && int'(vec_idx) == NT + 7, "stray ack no effect", int'(vec_idx), NT + 7);
        run(3, 1'b1);

        // Random mix against the model, both tables
        do_reset();
        for (int j = 0; j < NI; j++) set_src(j, int'($urandom_range(0, 7)), 1'($urandom_range(0, 3) != 0));
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(0, 3) == 0) irq_set[$urandom_range(0, NI - 1)] = 1'b1;
            if ($urandom_range(0, 40) == 0) trap_set[$urandom_range(0, NT - 1)] = 1'b1;
            if ($urandom_range(0, 50) == 0) cpu_prio = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 30) == 0) alt_sel = ~alt_sel;
            if ($urandom_range(0, 60) == 0) set_src(int'($urandom_range(0, NI - 1)), int'($urandom_range(0, 7)), 1'b1);
            tag = alt_sel ? "R8" : "R7";
            cpu_ack = 1'($urandom_range(0, 2) == 0);
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule